// File: doc/BRIEF.md
# Horizontal Drive Pulse Generator with Standby Timing

This block produces the periodic horizontal drive pulse for a display deflection path. It works in units of a 1 MHz timing tick. Each drive period lasts a set number of ticks, and the pulse is high for the first part of that period. In normal operation the tick comes from outside the block on `ext_tick_i`, and both the period length and the pulse width come from programmable inputs.

In standby the block ignores the external tick. It makes its own tick by dividing the 20 MHz main clock by 20. It then runs a fixed 64-tick period with a fixed pulse width, which is a parameter and defaults to 32 ticks.

A change of mode, period or width is taken only at a period boundary. The pulse that is in progress always finishes with the settings it started with. Out-of-range settings are clamped. Reset puts the block in standby with the output low.

All pins are plain control and timing signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `hdrive_gen`

## Requirements
- R1: While reset is asserted and after it is released, `drive_o` is low, and the block is in standby. The first rise comes on the 20th clock edge after reset is released, which is the first internal tick.
- R2: In standby the internal tick occurs once every 20 clock cycles. A standby period is 64 ticks long, which is 1280 clock cycles.
- R3: In standby the pulse is high for exactly 32 ticks (640 cycles) of each period, whatever value `width_i` holds.
- R4: In standby `ext_tick_i` has no effect on the pulse timing.
- R5: In normal mode (`standby_i` = 0) the period lasts `period_i` external ticks, and the pulse is high for the first `width_i` of them. `drive_o` changes only on a clock edge where the active tick is sampled high.
- R6: A change of `standby_i` takes effect only at the next period boundary. The pulse in progress completes unchanged, so no runt pulse is produced.
- R7: New `period_i` and `width_i` values are latched only at a period boundary.
- R8: A width of 0 is treated as 1. A width not less than the period is treated as period−1.
- R9: A period value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | 1 selects standby timing, 0 selects normal timing |
| ext_tick_i | input | 1 | One-cycle 1 MHz timing tick used in normal mode |
| period_i | input | PER_W (8) | Normal-mode period in ticks |
| width_i | input | PER_W (8) | Normal-mode pulse width in ticks |
| drive_o | output | 1 | Horizontal drive pulse |

## Verification
`drive_o` is registered. It moves one clock edge after the active tick is sampled, so every level is sampled at the falling clock edge. High and low times are counted in whole cycles between observed transitions.

The bench issues external ticks exactly every 4 cycles, so a normal-mode width of W ticks shows up as exactly 4·W high cycles. In standby, high and low times are 640 and 640 cycles.

A setting applied at a rise only shows up in the following period, so the bench always measures the period after the change. The first period after a mode switch has a phase offset of up to one tick. That period is either skipped or checked against a window one tick wide.

// File: rtl/hdrive_pkg.sv
package hdrive_pkg;
  typedef enum logic {
    MODE_STBY = 1'b0,
    MODE_NORM = 1'b1
  } hd_mode_e;
endpackage

// File: rtl/hd_tick_div.sv
module hd_tick_div #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hd_setting_sel.sv
module hd_setting_sel
  import hdrive_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int STBY_PERIOD = 64,
  parameter int STBY_WIDTH  = 32
) (
  input  logic             stby_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] width_i,
  output hd_mode_e         mode_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] wid_o
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic [PER_W-1:0] p_cl;

  always_comb begin
    p_cl = (period_i < MIN_PER) ? MIN_PER : period_i;
    if (stby_i) begin
      mode_o = MODE_STBY;
      per_o  = PER_W'(STBY_PERIOD);
      wid_o  = PER_W'(STBY_WIDTH);
    end else begin
      mode_o = MODE_NORM;
      per_o  = p_cl;
      if (width_i == '0)      wid_o = PER_W'(1);
      else if (width_i >= p_cl) wid_o = p_cl - PER_W'(1);
      else                      wid_o = width_i;
    end
  end
endmodule

// File: rtl/hd_period_ctr.sv
module hd_period_ctr
  import hdrive_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int STBY_PERIOD = 64,
  parameter int STBY_WIDTH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  hd_mode_e         nxt_mode_i,
  input  logic [PER_W-1:0] nxt_per_i,
  input  logic [PER_W-1:0] nxt_wid_i,
  output hd_mode_e         mode_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] wid_o,
  output logic [PER_W-1:0] phase_o,
  output logic             wrap_o,
  output logic             drive_o
);
  localparam logic [PER_W-1:0] RST_PER = PER_W'(STBY_PERIOD);
  localparam logic [PER_W-1:0] RST_WID = PER_W'(STBY_WIDTH);

  hd_mode_e         mode_q;
  logic [PER_W-1:0] per_q, wid_q, ph_q, ph_nx;
  logic             drv_q;

  assign wrap_o = tick_i && (ph_q == per_q - PER_W'(1));
  assign ph_nx  = ph_q + PER_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_STBY;
      per_q  <= RST_PER;
      wid_q  <= RST_WID;
      ph_q   <= RST_PER - PER_W'(1);
      drv_q  <= 1'b0;
    end else if (wrap_o) begin
      mode_q <= nxt_mode_i;
      per_q  <= nxt_per_i;
      wid_q  <= nxt_wid_i;
      ph_q   <= '0;
      drv_q  <= 1'b1;
    end else if (tick_i) begin
      ph_q   <= ph_nx;
      drv_q  <= (ph_nx < wid_q);
    end
  end

  assign mode_o  = mode_q;
  assign per_o   = per_q;
  assign wid_o   = wid_q;
  assign phase_o = ph_q;
  assign drive_o = drv_q;
endmodule

// File: rtl/hdrive_gen.sv
module hdrive_gen
  import hdrive_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int CLK_DIV     = 20,
  parameter int STBY_PERIOD = 64,
  parameter int STBY_WIDTH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             ext_tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] width_i,
  output logic             drive_o
);
  logic             stby_tick, sel_tick, wrap;
  hd_mode_e         nxt_mode, mode_q;
  logic [PER_W-1:0] nxt_per, nxt_wid, per_q, wid_q, phase_q;

  hd_tick_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_o(stby_tick)
  );

  assign sel_tick = (mode_q == MODE_STBY) ? stby_tick : ext_tick_i;

  hd_setting_sel #(
    .PER_W(PER_W), .STBY_PERIOD(STBY_PERIOD), .STBY_WIDTH(STBY_WIDTH)
  ) u_sel (
    .stby_i(standby_i), .period_i(period_i), .width_i(width_i),
    .mode_o(nxt_mode), .per_o(nxt_per), .wid_o(nxt_wid)
  );

  hd_period_ctr #(
    .PER_W(PER_W), .STBY_PERIOD(STBY_PERIOD), .STBY_WIDTH(STBY_WIDTH)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick_i(sel_tick),
    .nxt_mode_i(nxt_mode), .nxt_per_i(nxt_per), .nxt_wid_i(nxt_wid),
    .mode_o(mode_q), .per_o(per_q), .wid_o(wid_q), .phase_o(phase_q),
    .wrap_o(wrap), .drive_o(drive_o)
  );
endmodule

// File: rtl/hdrive_gen_chk.sv
module hdrive_gen_chk
  import hdrive_pkg::*;
#(
  parameter int PER_W   = 8,
  parameter int CLK_DIV = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_tick_i,
  input logic             drive_o,
  input logic             stby_tick,
  input logic             sel_tick,
  input logic             wrap,
  input hd_mode_e         mode_q,
  input logic [PER_W-1:0] per_q,
  input logic [PER_W-1:0] wid_q,
  input logic [PER_W-1:0] phase_q
);
  int gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || stby_tick) gap_q <= 0;
    else                     gap_q <= gap_q + 1;
  end

  // R1: output held low across reset
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !drive_o);

  // R2: internal tick spacing
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    stby_tick |-> gap_q == CLK_DIV - 1);

  // R4: external tick does nothing in standby
  a_r4_ext_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STBY && ext_tick_i && !stby_tick) |=> $stable(phase_q));

  // R5: output moves only after an active tick
  a_r5_drive_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_o) |-> $past(sel_tick));

  // R6: mode switches only at a period boundary
  a_r6_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(wrap));

  // R8: latched width always inside the period
  a_r8_width_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wid_q != '0) && (wid_q < per_q));
endmodule

bind hdrive_gen hdrive_gen_chk #(.PER_W(PER_W), .CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick_i), .drive_o(drive_o),
  .stby_tick(stby_tick), .sel_tick(sel_tick), .wrap(wrap),
  .mode_q(mode_q), .per_q(per_q), .wid_q(wid_q), .phase_q(phase_q)
);

// File: tb/test_hdrive_gen.sv
module test_hdrive_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby_i = 1'b1;
  logic       ext_tick_i = 1'b0;
  logic [7:0] period_i = 8'd10;
  logic [7:0] width_i = 8'd3;
  logic       drive_o;
  logic       tick_en = 1'b0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hdrive_gen i_hdrive_gen (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .ext_tick_i(ext_tick_i),
    .period_i(period_i), .width_i(width_i), .drive_o(drive_o)
  );

  // external tick: one cycle high every 4 cycles while enabled
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 4;
      ext_tick_i = tick_en && (tc == 0);
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_rise();
    logic prev = drive_o;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && drive_o) return;
      prev = drive_o;
    end
  endtask

  // called at the negedge of a first high sample; ends at the next one
  task automatic count(output int hi, output int lo);
    hi = 0; lo = 0;
    while (drive_o && hi < 5000) begin hi++; @(negedge clk); end
    while (!drive_o && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 low in reset", int'(drive_o), 0);
    rst_n = 1'b1;
    repeat (19) @(negedge clk);
    check("R1 low before first tick", int'(drive_o), 0);
    @(negedge clk);
    check("R1 rise on 20th edge", int'(drive_o), 1);
  endtask

  task automatic t_standby();
    int hi, lo;
    wait_rise();
    count(hi, lo);
    check("R3 standby width", hi, 640);
    check("R2 standby low part", lo, 640);
  endtask

  task automatic t_ext_ignored();
    int hi, lo;
    width_i = 8'd5;
    tick_en = 1'b1;
    wait_rise();
    count(hi, lo);
    check("R4 ext ticks ignored, width", hi, 640);
    check("R4 ext ticks ignored, low", lo, 640);
  endtask

  task automatic t_to_normal();
    int hi, lo;
    period_i = 8'd10; width_i = 8'd3;
    wait_rise();
    standby_i = 1'b0;
    count(hi, lo);
    check("R6 standby pulse finishes", hi, 640);
    check("R6 standby period finishes", lo, 640);
    count(hi, lo);
    count(hi, lo);
    check("R5 normal width", hi, 12);
    check("R5 normal low part", lo, 28);
  endtask

  task automatic t_latch();
    int hi, lo;
    wait_rise();
    width_i = 8'd7;
    count(hi, lo);
    check("R7 old width kept", hi, 12);
    count(hi, lo);
    check("R7 new width next period", hi, 28);
    check("R7 new low part", lo, 12);
  endtask

  task automatic t_clamp();
    int hi, lo;
    wait_rise(); width_i = 8'd0; count(hi, lo); count(hi, lo);
    check("R8 width 0 -> 1", hi, 4);
    check("R8 width 0 low part", lo, 36);
    wait_rise(); width_i = 8'd15; count(hi, lo); count(hi, lo);
    check("R8 width >= period -> period-1", hi, 36);
    check("R8 clamped low part", lo, 4);
    wait_rise(); period_i = 8'd1; width_i = 8'd0; count(hi, lo); count(hi, lo);
    check("R9 period 1 -> 2, width", hi, 4);
    check("R9 period 1 -> 2, low", lo, 4);
  endtask

  task automatic t_to_standby();
    int hi, lo;
    period_i = 8'd10; width_i = 8'd3;
    wait_rise(); count(hi, lo);
    standby_i = 1'b1;
    count(hi, lo);
    check("R6 normal pulse finishes", hi, 12);
    check("R6 normal period finishes", lo, 28);
    count(hi, lo);
    check_rng("R3 first standby width", hi, 621, 640);
    check("R2 first standby low part", lo, 640);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_ext_ignored();
    t_to_normal();
    t_latch();
    t_clamp();
    t_to_standby();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule